// File: doc/BRIEF.md
# Nonvolatile Shadow Store-Recall Controller

The block fronts a small word-addressed RAM that has a shadow nonvolatile array of the same size. The host uses active-low chip enable, output enable and write enable strobes, together with an address and write data. The controller gates ordinary reads and writes. It copies the RAM into the shadow array when the supply sags, and it copies the shadow back into the RAM when the supply returns. Three digital power flags drive the sequencing: supply below the switch level, supply below the reset level, and storage capacitor below the switch level.

A dirty flag records whether any write has been accepted since the last completed copy in either direction. An automatic or host-requested store only runs when the flag is set. A recall request is latched at reset and each time the supply drops below the reset level. It starts once both supply flags are clear. While the capacitor flag is set, host writes and host-requested stores are refused, but an automatic store still runs. A copy moves one word per cycle, and a recall first spends a fixed number of overhead cycles. During a copy the block reports busy, turns its data output off and ignores the host strobes. Each copy ends with a single-cycle done pulse. If a write strobe is active when a recall ends, a sticky corruption flag is raised.

Top module: `nv_shadow_ctrl`

## Requirements
- R1: While idle, with `ce_n_i`=0, `oe_n_i`=0 and `we_n_i`=1, `rdata_oe_o` is 1 and `rdata_o` equals the RAM word at `addr_i` in the same cycle. Otherwise `rdata_o` is 0.
- R2: While idle, with `ce_n_i`=0, `we_n_i`=0 and `cap_low_i`=0, `wdata_i` is stored at `addr_i` on the clock edge. Whenever `ce_n_i`=0 and `we_n_i`=0, `rdata_oe_o` is 0, even with `oe_n_i`=0.
- R3: While idle with the dirty flag set, `vdd_low_i`=1 starts a store on the next edge, whatever the value of `cap_low_i`. The store copies every RAM word into the shadow array, and `busy_o` stays 1 for exactly DEPTH cycles.
- R4: With the dirty flag clear, neither `vdd_low_i` nor `store_req_i` starts a store, and `busy_o` stays 0.
- R5: A recall request is latched at reset and on every cycle with `vdd_reset_i`=1. It is held until both `vdd_reset_i` and `vdd_low_i` are 0. The recall then starts on the next edge and keeps `busy_o` at 1 for RECALL_OVH+DEPTH cycles. Afterwards the RAM equals the shadow array.
- R6: While `cap_low_i`=1, host writes leave the RAM unchanged and `store_req_i` starts no store.
- R7: If `ce_n_i`=0 and `we_n_i`=0 on the final edge of a recall, `corrupt_o` becomes 1 and stays 1. The flag is cleared when the next recall starts.
- R8: An accepted write sets the dirty flag, and completing a store or a recall clears it.
- R9: While `busy_o`=1, host writes are ignored and `rdata_oe_o` is 0.
- R10: While idle, with the dirty flag set and `cap_low_i`=0, `store_req_i`=1 starts a store with the same timing as R3.
- R11: `done_o` is 1 for exactly one cycle, the first cycle after `busy_o` falls at the end of a store or a recall.
- R12: During reset, `busy_o`, `done_o`, `corrupt_o` and `rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vdd_low_i | input | 1 | Supply below switch level |
| vdd_reset_i | input | 1 | Supply below reset level |
| cap_low_i | input | 1 | Storage capacitor below switch level |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| store_req_i | input | 1 | Host store request |
| rdata_o | output | DATA_W | Read data, 0 when not driven |
| rdata_oe_o | output | 1 | Read data drive enable (0 means high impedance) |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle pulse at the end of a copy |
| corrupt_o | output | 1 | Sticky RAM corruption flag |

## Verification
Reads and the output-drive enable are combinational, so they are due in the cycle the strobes are applied. A write shows up on a read one cycle after its edge. A store or recall raises busy one edge after its trigger and holds it for DEPTH (or RECALL_OVH+DEPTH) cycles. Done and any corruption flag appear in the first cycle after busy falls. The bench drives inputs on the falling edge and samples 1 ns later. It counts busy cycles one falling edge at a time and checks done and corruption on the falling edge at which busy is first seen low. For each check it predicts the RAM and shadow contents arithmetically from the stimulus.

// File: rtl/nv_shadow_pkg.sv
// Shared types for the nonvolatile shadow controller.
// Assumes: the sequencer and the storage array agree on the copy direction code.
package nv_shadow_pkg;

    // Sequencer phase.
    typedef enum logic [1:0] {
        SEQ_IDLE     = 2'd0,
        SEQ_STORE    = 2'd1,
        SEQ_RCL_OVH  = 2'd2,
        SEQ_RCL_COPY = 2'd3
    } seq_state_e;

    // Direction of the word copy that is active in a given cycle.
    typedef enum logic [1:0] {
        COPY_NONE      = 2'd0,
        COPY_TO_SHADOW = 2'd1,
        COPY_TO_RAM    = 2'd2
    } copy_dir_e;

endpackage

// File: rtl/nv_cell.sv
// One word of volatile storage paired with its nonvolatile shadow.
// Assumes: ld_shadow and ld_ram are never both set; a host write and
// ld_ram are never both set (the top blocks host writes while busy).
module nv_cell #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_d,
    input  logic              ld_shadow,
    input  logic              ld_ram,
    output logic [DATA_W-1:0] ram_o,
    output logic [DATA_W-1:0] shadow_o
);

    logic [DATA_W-1:0] ram_q;
    logic [DATA_W-1:0] shadow_q;

    // Volatile word: a recall takes precedence, then a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_q <= '0;
        end else if (ld_ram) begin
            ram_q <= shadow_q;
        end else if (host_we) begin
            ram_q <= host_d;
        end
    end

    // Shadow word: loaded only by a store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (ld_shadow) begin
            shadow_q <= ram_q;
        end
    end

    assign ram_o    = ram_q;
    assign shadow_o = shadow_q;

endmodule

// File: rtl/nv_mem.sv
// Storage array: DEPTH word cells with a host write port, a host read mux,
// and a single-word copy port steered by the sequencer.
// Assumes: copy_idx addresses the word that moves in the current cycle.
module nv_mem
    import nv_shadow_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  copy_dir_e         copy_dir,
    input  logic [ADDR_W-1:0] copy_idx
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] ram_word    [DEPTH];
    logic [DATA_W-1:0] shadow_word [DEPTH];

    // Replicate one cell per word, each decoding its own selects.
    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic sel_copy;
        logic sel_host;

        assign sel_copy = (copy_idx == ADDR_W'(w));
        assign sel_host = wr_en && (wr_addr == ADDR_W'(w));

        nv_cell #(
            .DATA_W (DATA_W)
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .host_we   (sel_host),
            .host_d    (wr_data),
            .ld_shadow (sel_copy && (copy_dir == COPY_TO_SHADOW)),
            .ld_ram    (sel_copy && (copy_dir == COPY_TO_RAM)),
            .ram_o     (ram_word[w]),
            .shadow_o  (shadow_word[w])
        );
    end

    // Host read mux over the volatile words.
    assign rd_data = ram_word[rd_addr];

    // Shadow words are only observed through a recall.
    logic unused_shadow;
    always_comb begin
        unused_shadow = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            unused_shadow = unused_shadow ^ (^shadow_word[i]);
        end
    end

endmodule

// File: rtl/nv_seq.sv
// Store/recall sequencer: dirty tracking, the latched recall request,
// the start decision, the overhead and word counters, the done pulse and
// the corruption flag.
// Assumes: wr_accept_i is already qualified with idle and the capacitor flag.
module nv_seq
    import nv_shadow_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int RECALL_OVH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vdd_low_i,
    input  logic              vdd_reset_i,
    input  logic              cap_low_i,
    input  logic              store_req_i,
    input  logic              wr_accept_i,
    input  logic              wr_active_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              corrupt_o,
    output logic              dirty_o,
    output logic              pend_o,
    output copy_dir_e         copy_dir_o,
    output logic [ADDR_W-1:0] copy_idx_o
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int OVH_W = (RECALL_OVH > 1) ? $clog2(RECALL_OVH) : 1;
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);
    localparam logic [OVH_W-1:0]  LAST_OVH = OVH_W'(RECALL_OVH - 1);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] idx_q;
    logic [OVH_W-1:0]  ovh_q;
    logic              dirty_q, pend_q, done_q, corrupt_q;
    logic              start_store, start_recall, copying, finish;

    // Start decision: a store wins over a recall; both need the idle phase.
    always_comb begin
        start_store  = (state_q == SEQ_IDLE) && dirty_q &&
                       (vdd_low_i || (store_req_i && !cap_low_i));
        start_recall = (state_q == SEQ_IDLE) && !start_store && pend_q &&
                       !vdd_low_i && !vdd_reset_i;
        copying      = (state_q == SEQ_STORE) || (state_q == SEQ_RCL_COPY);
        finish       = copying && (idx_q == LAST_IDX);
    end

    // Next phase.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_store) begin
                    state_d = SEQ_STORE;
                end else if (start_recall) begin
                    state_d = SEQ_RCL_OVH;
                end
            end
            SEQ_STORE:    if (finish) state_d = SEQ_IDLE;
            SEQ_RCL_OVH:  if (ovh_q == LAST_OVH) state_d = SEQ_RCL_COPY;
            SEQ_RCL_COPY: if (finish) state_d = SEQ_IDLE;
            default:      state_d = SEQ_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Word counter: advances during a copy, wraps to zero at the last word.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx_q <= '0;
        else if (copying) idx_q <= idx_q + 1'b1;
        else              idx_q <= '0;
    end

    // Overhead counter for the recall preamble.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ovh_q <= '0;
        else if (state_q == SEQ_RCL_OVH)  ovh_q <= ovh_q + 1'b1;
        else                              ovh_q <= '0;
    end

    // Dirty flag: cleared by a finished copy, set by an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)           dirty_q <= 1'b0;
        else if (finish)      dirty_q <= 1'b0;
        else if (wr_accept_i) dirty_q <= 1'b1;
    end

    // Recall request: latched at reset and on low supply, dropped at start.
    always_ff @(posedge clk) begin
        if (!rst_n)            pend_q <= 1'b1;
        else if (vdd_reset_i)  pend_q <= 1'b1;
        else if (start_recall) pend_q <= 1'b0;
    end

    // One-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= finish;
    end

    // Sticky corruption flag: write strobe seen on the last recall edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            corrupt_q <= 1'b0;
        else if (start_recall)
            corrupt_q <= 1'b0;
        else if (finish && (state_q == SEQ_RCL_COPY) && wr_active_i)
            corrupt_q <= 1'b1;
    end

    // Copy steering toward the storage array.
    always_comb begin
        copy_dir_o = COPY_NONE;
        if (state_q == SEQ_STORE)         copy_dir_o = COPY_TO_SHADOW;
        else if (state_q == SEQ_RCL_COPY) copy_dir_o = COPY_TO_RAM;
    end

    assign copy_idx_o = idx_q;
    assign busy_o     = (state_q != SEQ_IDLE);
    assign done_o     = done_q;
    assign corrupt_o  = corrupt_q;
    assign dirty_o    = dirty_q;
    assign pend_o     = pend_q;

endmodule

// File: rtl/nv_shadow_ctrl.sv
// Top of the nonvolatile shadow controller: host strobe decoding,
// output-drive gating, the sequencer and the storage array.
// Assumes: power flags are already synchronous to clk.
module nv_shadow_ctrl
    import nv_shadow_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int RECALL_OVH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vdd_low_i,
    input  logic              vdd_reset_i,
    input  logic              cap_low_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              store_req_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_oe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              corrupt_o
);

    logic              wr_active, wr_accept, rd_active;
    logic              busy, dirty, pend;
    copy_dir_e         copy_dir;
    logic [ADDR_W-1:0] copy_idx;
    logic [DATA_W-1:0] mem_rd;

    // Host strobe decode, qualified by the sequencer and the capacitor flag.
    always_comb begin
        wr_active = !ce_n_i && !we_n_i;
        wr_accept = wr_active && !busy && !cap_low_i;
        rd_active = !ce_n_i && !oe_n_i && we_n_i && !busy;
    end

    nv_seq #(
        .ADDR_W     (ADDR_W),
        .RECALL_OVH (RECALL_OVH)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .vdd_low_i   (vdd_low_i),
        .vdd_reset_i (vdd_reset_i),
        .cap_low_i   (cap_low_i),
        .store_req_i (store_req_i),
        .wr_accept_i (wr_accept),
        .wr_active_i (wr_active),
        .busy_o      (busy),
        .done_o      (done_o),
        .corrupt_o   (corrupt_o),
        .dirty_o     (dirty),
        .pend_o      (pend),
        .copy_dir_o  (copy_dir),
        .copy_idx_o  (copy_idx)
    );

    nv_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_accept),
        .wr_addr  (addr_i),
        .wr_data  (wdata_i),
        .rd_addr  (addr_i),
        .rd_data  (mem_rd),
        .copy_dir (copy_dir),
        .copy_idx (copy_idx)
    );

    // Read data is forced to zero whenever the output is not driven.
    assign rdata_oe_o = rd_active;
    assign rdata_o    = rd_active ? mem_rd : '0;
    assign busy_o     = busy;

endmodule

// File: rtl/nv_shadow_ctrl_chk.sv
// Property checker for nv_shadow_ctrl, attached with bind.
// Assumes: dirty and pend are the sequencer's registered flags.
module nv_shadow_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic vdd_reset_i,
    input logic cap_low_i,
    input logic rdata_oe_o,
    input logic busy_o,
    input logic done_o,
    input logic corrupt_o,
    input logic dirty,
    input logic pend
);

    AST_BUSY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !rdata_oe_o);                                  // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                      // R11
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));                   // R11
    AST_CAP_KEEPS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_low_i && !dirty && !busy_o) |=> !dirty);             // R6
    AST_CLEAN_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !dirty && !pend) |=> !busy_o);                // R4
    AST_CORRUPT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(corrupt_o) |-> done_o);                             // R7
    AST_DONE_CLEARS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !dirty);                                       // R8
    AST_RECALL_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_reset_i |=> pend);                                    // R5

endmodule

bind nv_shadow_ctrl nv_shadow_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vdd_reset_i (vdd_reset_i),
    .cap_low_i   (cap_low_i),
    .rdata_oe_o  (rdata_oe_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .corrupt_o   (corrupt_o),
    .dirty       (dirty),
    .pend        (pend)
);

// File: tb/nv_shadow_ctrl_tb.sv
// Bench for nv_shadow_ctrl: sweeps every word, predicts contents arithmetically.
module nv_shadow_ctrl_tb;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int OVH    = 3;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              vdd_low = 1'b1, vdd_reset = 1'b1, cap_low = 1'b0;
    logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, store_req = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              rdata_oe, busy, done, corrupt;

    int n_chk = 0;
    int n_fail = 0;
    int exp_ram [DEPTH];
    int exp_sh  [DEPTH];

    always #2 clk = ~clk;

    nv_shadow_ctrl #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .RECALL_OVH (OVH)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .vdd_low_i (vdd_low), .vdd_reset_i (vdd_reset),
        .cap_low_i (cap_low), .ce_n_i (ce_n), .oe_n_i (oe_n), .we_n_i (we_n),
        .addr_i (addr), .wdata_i (wdata), .store_req_i (store_req),
        .rdata_o (rdata), .rdata_oe_o (rdata_oe), .busy_o (busy),
        .done_o (done), .corrupt_o (corrupt)
    );

    task automatic check(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic bus_idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; store_req = 1'b0;
    endtask

    // Write one word with oe also active; the output must stay off.
    task automatic write_word(input int a, input int d, input bit accept);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = ADDR_W'(a); wdata = DATA_W'(d);
        #1 check("R2", "rdata_oe during write", int'(rdata_oe), 0);
        if (accept) exp_ram[a] = d;
    endtask

    task automatic read_all(input string rq);
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = ADDR_W'(a);
            #1 check(rq, "rdata_oe", int'(rdata_oe), 1);
            check(rq, $sformatf("rdata[%0d]", a), int'(rdata), exp_ram[a]);
        end
        @(negedge clk); bus_idle();
        #1 check("R1", "rdata when not driven", int'(rdata), 0);
    endtask

    // Count busy cycles after a trigger; idle the bus when done appears.
    task automatic op_len(input int exp_len, input string rq);
        int n = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            #1;
            if (!busy) break;
            n++;
        end
        bus_idle();
        check(rq, "busy cycles", n, exp_len);
        check("R11", "done after busy", int'(done), 1);
        @(negedge clk);
        #1 check("R11", "done single cycle", int'(done), 0);
    endtask

    task automatic stay_idle(input int cycles, input string rq);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            #1 check(rq, "busy stays low", int'(busy), 0);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-requirements: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) begin exp_ram[a] = 0; exp_sh[a] = 0; end

        // R12: reset state under power-up flags.
        repeat (4) @(negedge clk);
        #1;
        check("R12", "busy in reset", int'(busy), 0);
        check("R12", "done in reset", int'(done), 0);
        check("R12", "corrupt in reset", int'(corrupt), 0);
        check("R12", "rdata in reset", int'(rdata), 0);

        // R5: latched recall waits for both supply flags to clear.
        @(negedge clk); rst_n = 1'b1;
        stay_idle(2, "R5");
        @(negedge clk); vdd_reset = 1'b0;
        #1 check("R5", "busy with vdd_low set", int'(busy), 0);
        stay_idle(2, "R5");
        @(negedge clk); vdd_low = 1'b0;
        op_len(OVH + DEPTH, "R5");
        read_all("R1");

        // R2/R1: write pattern f over every word, then read it back.
        for (int a = 0; a < DEPTH; a++) write_word(a, (a * 37 + 5) & 255, 1'b1);
        @(negedge clk); bus_idle();
        read_all("R2");

        // R6: capacitor low refuses writes and host stores.
        @(negedge clk); cap_low = 1'b1;
        write_word(3, 8'hEE, 1'b0);
        @(negedge clk); bus_idle(); store_req = 1'b1;
        stay_idle(3, "R6");
        @(negedge clk); store_req = 1'b0;
        read_all("R6");

        // R10: host store with dirty set and capacitor fine.
        @(negedge clk); cap_low = 1'b0; store_req = 1'b1;
        for (int a = 0; a < DEPTH; a++) exp_sh[a] = exp_ram[a];
        op_len(DEPTH, "R10");

        // R4: clean array ignores both store triggers.
        @(negedge clk); store_req = 1'b1;
        stay_idle(3, "R4");
        @(negedge clk); store_req = 1'b0; vdd_low = 1'b1;
        stay_idle(3, "R4");
        @(negedge clk); vdd_low = 1'b0;

        // R3: pattern g, then auto store with the capacitor flag set.
        for (int a = 0; a < DEPTH; a++) write_word(a, a ^ 8'hA5, 1'b1);
        @(negedge clk); bus_idle(); cap_low = 1'b1; vdd_low = 1'b1;
        for (int a = 0; a < DEPTH; a++) exp_sh[a] = exp_ram[a];
        // R9: strobes during the store are ignored.
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = '0; wdata = 8'h11;
        #1 check("R9", "busy during store", int'(busy), 1);
        check("R9", "rdata_oe while busy", int'(rdata_oe), 0);
        op_len(DEPTH - 1, "R3");
        // R8: store cleared dirty, so a held supply-low flag does nothing.
        stay_idle(3, "R8");
        @(negedge clk); cap_low = 1'b0;
        write_word(5, 8'h77, 1'b1);
        exp_sh[5] = 8'h77;
        @(negedge clk); bus_idle();
        op_len(DEPTH, "R8");
        @(negedge clk); vdd_low = 1'b0;
        read_all("R9");

        // R5: overwrite with pattern h, recall restores the shadow.
        for (int a = 0; a < DEPTH; a++) write_word(a, (a * 11) & 255, 1'b1);
        @(negedge clk); bus_idle(); vdd_reset = 1'b1;
        stay_idle(2, "R5");
        @(negedge clk); vdd_reset = 1'b0;
        for (int a = 0; a < DEPTH; a++) exp_ram[a] = exp_sh[a];
        op_len(OVH + DEPTH, "R5");
        read_all("R5");
        @(negedge clk); vdd_low = 1'b1;
        stay_idle(3, "R8");
        @(negedge clk); vdd_low = 1'b0;

        // R7: write strobe held through a recall raises corruption.
        @(negedge clk); vdd_reset = 1'b1;
        @(negedge clk); vdd_reset = 1'b0;
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = '0; wdata = 8'h5A;
        op_len(OVH + DEPTH, "R7");
        check("R7", "corrupt after recall", int'(corrupt), 1);
        stay_idle(2, "R7");
        check("R7", "corrupt sticky", int'(corrupt), 1);
        read_all("R7");

        // R7: next recall clears the flag at its start.
        @(negedge clk); vdd_reset = 1'b1;
        @(negedge clk); vdd_reset = 1'b0;
        @(negedge clk);
        #1 check("R7", "busy at recall start", int'(busy), 1);
        check("R7", "corrupt cleared at start", int'(corrupt), 0);
        op_len(OVH + DEPTH - 1, "R5");
        check("R7", "corrupt after clean recall", int'(corrupt), 0);

        report();
        $finish;
    end

endmodule